// File: doc/BRIEF.md
# Chip-select-to-clock delay timer

This block times the programmable pauses that frame each serial word on an SPI-style link. There are three pauses: from chip-select assertion to the first clock edge (lead), from the last clock edge to chip-select negation (trail), and the idle gap between two frames. The shift engine raises one start strobe per pause. The timer counts out the pause in system clocks and then returns a single-cycle done pulse, with a tag that names the pause that finished.

Each pause is the product of two factors. The first is an odd prescaler chosen by a 2-bit code. The second is a power-of-two scaler chosen by a 4-bit code. All six codes sit in one 24-bit timing word that a neighbouring register supplies, so the field positions are fixed.

Top module: `csdly_timer`

## Requirements
- R1: A lead start produces a pause of P*2^(S+1) clocks. P comes from timing-word bits 23:22 (codes 0,1,2,3 give 1,3,5,7) and S from bits 15:12.
- R2: A trail start uses the same arithmetic, with the prescaler code at bits 21:20 and the scaler code at bits 11:8.
- R3: A gap start uses the same arithmetic, with the prescaler code at bits 19:18 and the scaler code at bits 7:4.
- R4: If a start is sampled in cycle 0 and the pause is N, then done is high for exactly one cycle, cycle N. busy is high from cycle 1 through cycle N and low again in cycle N+1.
- R5: With both codes at zero the pause is exactly 2 clocks.
- R6: A start strobe sampled while busy is high is ignored, and this includes the done cycle. Timing and tag of the running pause are unchanged, and no extra done follows.
- R7: When several strobes arrive together, lead wins over trail and trail wins over gap. doneKind reads 0 for lead, 1 for trail and 2 for gap during the done cycle.
- R8: The codes are captured at the accepted start. Changes to the timing word during a pause do not alter its length.
- R9: After reset, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timingWord | input | 24 | Packed prescaler and scaler codes for the three pauses |
| startLead | input | 1 | Start the chip-select-to-clock pause |
| startTrail | input | 1 | Start the clock-to-chip-select pause |
| startGap | input | 1 | Start the between-frame pause |
| busy | output | 1 | A pause is being counted |
| done | output | 1 | One-cycle pulse when the pause has expired |
| doneKind | output | 2 | Which pause finished (0 lead, 1 trail, 2 gap) |

## Verification
The assertions assume that the start strobes and the timing word are free of X after reset. They also assume that a strobe can arrive in any cycle, including while a pause is running, and so they check rejection rather than forbid such strobes. The stimulus changes inputs only on the falling clock edge. It deliberately fires strobes in the middle of a pause, during the done cycle and several at once, and it rewrites the timing word mid-pause. The codes are swept over every prescaler value and over the low scaler codes, which keeps the total number of cycles bounded.

// File: rtl/csdly_pkg.sv
package csdly_pkg;
  localparam int PRE_W = 2;
  localparam int SC_W = 4;
  localparam int NUM_KINDS = 3;
  localparam int CFG_W = 24;
  // largest odd prescaler needs PRE_W+1 bits, shifted by up to 2^SC_W
  localparam int CNT_W = PRE_W + 1 + (1 << SC_W);

  typedef enum logic [1:0] {
    KIND_LEAD  = 2'd0,
    KIND_TRAIL = 2'd1,
    KIND_GAP   = 2'd2
  } kind_e;

  typedef struct packed {
    logic  load;
    kind_e kind;
  } ctrl_t;

  // field positions are decoded by the neighbour that builds the timing word
  function automatic int preLsb(int k);
    return 22 - 2 * k;
  endfunction

  function automatic int scLsb(int k);
    return 12 - 4 * k;
  endfunction
endpackage

// File: rtl/csdly_ctrl.sv
module csdly_ctrl
  import csdly_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startLead,
  input  logic       startTrail,
  input  logic       startGap,
  input  logic       expired,
  output ctrl_t      ctrl,
  output logic       busy,
  output logic       done,
  output logic [1:0] doneKind
);
  logic  anyStart;
  logic  accept;
  kind_e selKind;
  kind_e kindReg;

  assign anyStart = startLead | startTrail | startGap;
  assign accept = anyStart & ~busy;

  always_comb begin
    if (startLead)       selKind = KIND_LEAD;
    else if (startTrail) selKind = KIND_TRAIL;
    else                 selKind = KIND_GAP;
  end

  assign ctrl.load = accept;
  assign ctrl.kind = selKind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      kindReg <= KIND_LEAD;
    end else if (accept) begin
      busy    <= 1'b1;
      kindReg <= selKind;
    end else if (busy && expired) begin
      busy <= 1'b0;
    end
  end

  assign done = busy & expired;
  assign doneKind = kindReg;

  // R4: done lasts a single cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4: an accepted start makes the timer busy next cycle
  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (anyStart && !busy) |=> busy);
  // R5: never done in the first busy cycle (minimum pause of two)
  p_min_two_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !done);
  // R6: tag of a running pause is not disturbed by new strobes
  p_tag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy && $stable(kindReg)));
  // R4: timer falls idle right after done
  p_idle_after_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

// File: rtl/csdly_datapath.sv
module csdly_datapath
  import csdly_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] timingWord,
  input  ctrl_t            ctrl,
  output logic             expired
);
  logic [PRE_W-1:0] preCode [NUM_KINDS];
  logic [SC_W-1:0]  scCode  [NUM_KINDS];
  logic [CNT_W-1:0] kindLen [NUM_KINDS];
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic [PRE_W:0] oddPre;
    logic [SC_W:0]  shiftAmt;
    assign preCode[k] = timingWord[preLsb(k) +: PRE_W];
    assign scCode[k]  = timingWord[scLsb(k) +: SC_W];
    assign oddPre = {preCode[k], 1'b1};
    assign shiftAmt = {1'b0, scCode[k]} + {{SC_W{1'b0}}, 1'b1};
    assign kindLen[k] = CNT_W'(oddPre) << shiftAmt;
  end

  always_comb begin
    case (ctrl.kind)
      KIND_LEAD:  loadVal = kindLen[0] - CNT_W'(1);
      KIND_TRAIL: loadVal = kindLen[1] - CNT_W'(1);
      default:    loadVal = kindLen[2] - CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                count <= '0;
    else if (ctrl.load)       count <= loadVal;
    else if (count != '0)     count <= count - CNT_W'(1);
  end

  assign expired = (count == '0);

  // R4: counter steps down by one each cycle until it expires
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && count != '0) |=> (count == $past(count) - CNT_W'(1)));
  // R5: every loaded count is at least one, giving two or more cycles
  p_load_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (count != '0));
endmodule

// File: rtl/csdly_timer.sv
module csdly_timer
  import csdly_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [23:0] timingWord,
  input  logic        startLead,
  input  logic        startTrail,
  input  logic        startGap,
  output logic        busy,
  output logic        done,
  output logic [1:0]  doneKind
);
  ctrl_t ctrl;
  logic  expired;

  csdly_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startLead  (startLead),
    .startTrail (startTrail),
    .startGap   (startGap),
    .expired    (expired),
    .ctrl       (ctrl),
    .busy       (busy),
    .done       (done),
    .doneKind   (doneKind)
  );

  csdly_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .timingWord (timingWord),
    .ctrl       (ctrl),
    .expired    (expired)
  );
endmodule

// File: tb/sim_csdly_timer.sv
module sim_csdly_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] timingWord = '0;
  logic        startLead = 1'b0;
  logic        startTrail = 1'b0;
  logic        startGap = 1'b0;
  logic        busy, done;
  logic [1:0]  doneKind;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  csdly_timer u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] packWord(input int kind, input int pre, input int sc);
    logic [23:0] w = '0;
    w[22 - 2 * kind +: 2] = pre[1:0];
    w[12 - 4 * kind +: 4] = sc[3:0];
    return w;
  endfunction

  // pulse start on a falling edge, count cycles until done; returns cycles
  task automatic runPause(input int kind, input logic [2:0] strobes,
                          input bit midChange, output int cycles, output int kindSeen);
    cycles = 0;
    startLead = strobes[0]; startTrail = strobes[1]; startGap = strobes[2];
    @(negedge clk);
    startLead = 0; startTrail = 0; startGap = 0;
    cycles = 1;
    while (!done && cycles < 500000) begin
      if (midChange && cycles == 2) begin
        timingWord = ~timingWord;
        startTrail = 1'b1;
      end else begin
        startTrail = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    startTrail = 1'b0;
    kindSeen = int'(doneKind);
    if (kind < 0) kindSeen = kindSeen;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc, kd, expN;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R9 reset state", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3: sweep every prescaler and low scaler codes for each pause
    for (int kind = 0; kind < 3; kind++) begin
      int scMax = (kind == 0) ? 9 : ((kind == 1) ? 5 : 3);
      for (int pre = 0; pre < 4; pre++) begin
        for (int sc = 0; sc <= scMax; sc++) begin
          timingWord = packWord(kind, pre, sc);
          expN = (2 * pre + 1) << (sc + 1);
          runPause(kind, 3'b1 << kind, 1'b0, cyc, kd);
          if (kind == 0) check(cyc == expN, "R1 lead length", cyc, expN);
          else if (kind == 1) check(cyc == expN, "R2 trail length", cyc, expN);
          else check(cyc == expN, "R3 gap length", cyc, expN);
          check(kd == kind, "R7 tag", kd, kind);
          // R6: start during the done cycle is ignored
          startGap = 1'b1;
          @(negedge clk);
          startGap = 1'b0;
          check(!done && !busy, "R4 R6 single pulse and idle", {busy, done}, 0);
        end
      end
    end

    // R5: both codes zero
    timingWord = 24'h0;
    runPause(1, 3'b010, 1'b0, cyc, kd);
    check(cyc == 2, "R5 minimum pause", cyc, 2);
    @(negedge clk);

    // R6 R8: strobe and word change mid-pause do not disturb it
    timingWord = packWord(0, 2, 3);
    runPause(0, 3'b001, 1'b1, cyc, kd);
    check(cyc == 80, "R6 R8 mid-pause disturbance", cyc, 80);
    check(kd == 0, "R6 tag kept", kd, 0);
    @(negedge clk);
    check(!busy, "R6 no extra pause", busy, 0);

    // R7: simultaneous strobes
    timingWord = packWord(0, 1, 0) | packWord(1, 3, 2) | packWord(2, 2, 1);
    runPause(0, 3'b111, 1'b0, cyc, kd);
    check(cyc == 6 && kd == 0, "R7 lead wins", cyc * 4 + kd, 24);
    @(negedge clk);
    runPause(1, 3'b110, 1'b0, cyc, kd);
    check(cyc == 56 && kd == 1, "R7 trail over gap", cyc * 4 + kd, 225);
    @(negedge clk);

    // R4: busy through the pause
    timingWord = packWord(2, 1, 1);
    startGap = 1'b1;
    @(negedge clk);
    startGap = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      check(busy == 1'b1 && done == (i == 12), "R4 busy window", {busy, done}, (i == 12) ? 3 : 2);
      @(negedge clk);
    end
    check(!busy, "R4 idle after done", busy, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule